// File: doc/BRIEF.md
# Paired Status/Data Input Port

This block is an 8-bit parallel input port that occupies two neighbouring I/O addresses. The odd address of the pair returns the captured input byte. The even address returns a status byte that says whether a byte is waiting. A 4-bit switch code places the pair on any even base from 00h to 1Eh. An external device such as a keyboard or a bank of sensors raises a positive strobe. A long enough strobe captures the byte and raises a pending flag.

The pending flag also drives an active-low interrupt request, which stays asserted until software reads the data address. The strobe pin is synchronised to the system clock. It is accepted only after it has stayed high for a programmable number of clocks, so glitches and short pulses are rejected. While an accepted strobe is still high, the data register follows the input pins on every clock. Tying the strobe high therefore turns the port into a transparent, polled sensor input.

Top module: `pio_pair_port`

## Requirements
- R1: The port answers a read only when bits 7..5 of the 8-bit I/O address are all zero; any other address gives read data 00h and leaves the pending flag unchanged.
- R2: The port answers only when address bits 4..1 equal the 4-bit switch code, so the base can be any even address from 00h to 1Eh.
- R3: Address bit 0 equal to 0 selects the status byte; address bit 0 equal to 1 selects the data byte.
- R4: A read happens only while both the input-cycle status and the read strobe are high; otherwise read data is 00h and the pending flag is not cleared.
- R5: Status bit 0 is the active-low data-available flag (0 means a byte is waiting); status bits 7..1 always read 1.
- R6: The interrupt output is low while a byte is pending. It returns high on the clock after a read of the data address.
- R7: After two synchroniser stages, a strobe that stays high for at least MIN_W consecutive clocks captures the input byte and sets the pending flag. With MIN_W = 4, the interrupt output is low by the sixth rising clock edge after the strobe rises.
- R8: A strobe pulse shorter than MIN_W synchronised clocks is ignored: the data register and the pending flag keep their values.
- R9: While an accepted strobe remains high, the data register reloads from the input pins on every clock, so a strobe tied high gives transparent live data.
- R10: After synchronous reset the interrupt output is high, the data register holds 00h and the status byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O port address |
| in_cycle | input | 1 | Bus status: the current cycle is an input read |
| rd_stb | input | 1 | Read strobe |
| stb_pin | input | 1 | Asynchronous capture strobe from the external device |
| ext_data | input | 8 | External input byte |
| sw_code | input | 4 | Switch code that sets address bits 4..1 of the pair |
| rd_data | output | 8 | Read data; 00h when the port is not selected |
| irq_n | output | 1 | Active-low interrupt request, low while a byte is pending |

## Verification
The bench drives a strobe that is one clock shorter than the minimum width. A design that counts badly would capture that byte and drop the interrupt line. The bench reads at addresses that differ from the pair only in the upper bits or in the switch field. It also reads with only one of the two read qualifiers. A loose decoder would return data there, or would clear the pending flag and release the interrupt early. It moves the switch code to the top pair and holds the strobe high while the input changes. This catches a decoder that ignores a switch bit and a register that captures only once.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        PSEL_NONE = 2'd0,
        PSEL_STAT = 2'd1,
        PSEL_DATA = 2'd2
    } psel_e;

    typedef struct packed {
        logic       pend;
        logic [7:0] byte_q;
    } port_state_t;

    function automatic psel_e decode_pair(
        input logic [7:0] addr,
        input logic [3:0] code
    );
        psel_e r;
        r = PSEL_NONE;
        if (addr[7:5] == 3'b000 && addr[4:1] == code)
            r = addr[0] ? PSEL_DATA : PSEL_STAT;
        return r;
    endfunction

endpackage

// File: rtl/pio_strobe_qual.sv
module pio_strobe_qual #(
    parameter int MIN_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_pin,
    output logic accept,
    output logic open_q
);
    localparam int CW = $clog2(MIN_W + 1);

    logic [SYNC_N-1:0] sync_q;
    logic [CW-1:0]     width_q;
    logic              stb_s;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_N-2:0], stb_pin};
    end

    assign stb_s = sync_q[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst || !stb_s)
            width_q <= '0;
        else if (width_q != CW'(MIN_W))
            width_q <= width_q + 1'b1;
    end

    assign accept = stb_s && (width_q == CW'(MIN_W - 1));
    assign open_q = stb_s && (width_q >= CW'(MIN_W - 1));
endmodule

// File: rtl/pio_hold_reg.sv
module pio_hold_reg
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              open_q,
    input  logic              data_rd,
    input  logic [DATA_W-1:0] ext_data,
    output port_state_t       st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (open_q)
                st.byte_q <= ext_data;
            if (accept)
                st.pend <= 1'b1;
            else if (data_rd)
                st.pend <= 1'b0;
        end
    end
endmodule

// File: rtl/pio_pair_port.sv
module pio_pair_port
    import pio_pkg::*;
#(
    parameter int MIN_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] io_addr,
    input  logic       in_cycle,
    input  logic       rd_stb,
    input  logic       stb_pin,
    input  logic [7:0] ext_data,
    input  logic [3:0] sw_code,
    output logic [7:0] rd_data,
    output logic       irq_n
);
    localparam logic [6:0] STAT_FILL = '1;

    logic        accept, open_q, rd_act, data_rd;
    psel_e       sel;
    port_state_t st;

    pio_strobe_qual #(.MIN_W(MIN_W), .SYNC_N(SYNC_N)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .stb_pin(stb_pin),
        .accept (accept),
        .open_q (open_q)
    );

    assign rd_act  = in_cycle && rd_stb;
    assign sel     = decode_pair(io_addr, sw_code);
    assign data_rd = rd_act && (sel == PSEL_DATA);

    pio_hold_reg #(.DATA_W(8)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .open_q  (open_q),
        .data_rd (data_rd),
        .ext_data(ext_data),
        .st      (st)
    );

    always_comb begin
        rd_data = 8'h00;
        if (rd_act) begin
            unique case (sel)
                PSEL_STAT: rd_data = {STAT_FILL, ~st.pend};
                PSEL_DATA: rd_data = st.byte_q;
                default:   rd_data = 8'h00;
            endcase
        end
    end

    assign irq_n = ~st.pend;
endmodule

// File: rtl/pio_pair_port_chk.sv
module pio_pair_port_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] io_addr,
    input logic       in_cycle,
    input logic       rd_stb,
    input logic [3:0] sw_code,
    input logic [7:0] rd_data,
    input logic       irq_n,
    input logic       accept
);
    a_r1_upper_bits_silent: assert property (@(posedge clk) disable iff (rst)
        (io_addr[7:5] != 3'b000) |-> (rd_data == 8'h00));

    a_r2_switch_mismatch_silent: assert property (@(posedge clk) disable iff (rst)
        (io_addr[4:1] != sw_code) |-> (rd_data == 8'h00));

    a_r4_needs_both_qualifiers: assert property (@(posedge clk) disable iff (rst)
        !(in_cycle && rd_stb) |-> (rd_data == 8'h00));

    a_r5_status_layout: assert property (@(posedge clk) disable iff (rst)
        (in_cycle && rd_stb && io_addr[7:5] == 3'b000 && io_addr[4:1] == sw_code && !io_addr[0])
        |-> (rd_data[7:1] == 7'h7F && rd_data[0] == irq_n));

    a_r6_data_read_releases_irq: assert property (@(posedge clk) disable iff (rst)
        (in_cycle && rd_stb && io_addr[7:5] == 3'b000 && io_addr[4:1] == sw_code && io_addr[0] && !accept)
        |=> irq_n);

    a_r8_irq_falls_only_on_accept: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(accept));
endmodule

bind pio_pair_port pio_pair_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .io_addr (io_addr),
    .in_cycle(in_cycle),
    .rd_stb  (rd_stb),
    .sw_code (sw_code),
    .rd_data (rd_data),
    .irq_n   (irq_n),
    .accept  (accept)
);

// File: tb/test_pio_pair_port.sv
module test_pio_pair_port;
    localparam time CLK_P = 10ns;
    localparam int  MIN_W = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] io_addr = 8'h00;
    logic       in_cycle = 1'b0;
    logic       rd_stb = 1'b0;
    logic       stb_pin = 1'b0;
    logic [7:0] ext_data = 8'h00;
    logic [3:0] sw_code = 4'h5;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] got;

    always #(CLK_P/2) clk = ~clk;

    pio_pair_port #(.MIN_W(MIN_W), .SYNC_N(2)) i_pio_pair_port (
        .clk(clk), .rst(rst), .io_addr(io_addr), .in_cycle(in_cycle),
        .rd_stb(rd_stb), .stb_pin(stb_pin), .ext_data(ext_data),
        .sw_code(sw_code), .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic c, input logic s, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; in_cycle = c; rd_stb = s;
        #1 v = rd_data;
        @(negedge clk);
        in_cycle = 1'b0; rd_stb = 1'b0; io_addr = 8'h00;
        #1;
    endtask

    task automatic pulse(input logic [7:0] d, input int n);
        @(negedge clk);
        ext_data = d; stb_pin = 1'b1;
        repeat (n) @(negedge clk);
        stb_pin = 1'b0;
        repeat (MIN_W + 4) @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        check("R10 irq_n after reset", {7'h0, irq_n}, 8'h01);
        rd(8'h0A, 1, 1, got); check("R10 status after reset", got, 8'hFF);
        rd(8'h0B, 1, 1, got); check("R10 data after reset", got, 8'h00);
    endtask

    task automatic t_capture;
        pulse(8'hA5, MIN_W);
        check("R7 irq_n low after full strobe", {7'h0, irq_n}, 8'h00);
        rd(8'h0A, 1, 1, got); check("R5 status pending", got, 8'hFE);
        check("R5 status read keeps irq", {7'h0, irq_n}, 8'h00);
        rd(8'h0B, 1, 1, got); check("R3 R7 data byte", got, 8'hA5);
        check("R6 irq_n released after data read", {7'h0, irq_n}, 8'h01);
        rd(8'h0A, 1, 1, got); check("R5 status idle", got, 8'hFF);
    endtask

    task automatic t_short;
        pulse(8'h3C, MIN_W - 1);
        check("R8 short strobe irq", {7'h0, irq_n}, 8'h01);
        rd(8'h0B, 1, 1, got); check("R8 short strobe data kept", got, 8'hA5);
    endtask

    task automatic t_decode;
        pulse(8'h5A, MIN_W + 1);
        rd(8'h2B, 1, 1, got); check("R1 upper bits set", got, 8'h00);
        rd(8'h0D, 1, 1, got); check("R2 switch mismatch", got, 8'h00);
        check("R1 R2 stray reads keep irq", {7'h0, irq_n}, 8'h00);
        rd(8'h0B, 1, 0, got); check("R4 in_cycle only", got, 8'h00);
        rd(8'h0B, 0, 1, got); check("R4 rd_stb only", got, 8'h00);
        check("R4 partial reads keep irq", {7'h0, irq_n}, 8'h00);
        rd(8'h0B, 1, 1, got); check("R3 data after stray reads", got, 8'h5A);
    endtask

    task automatic t_top_pair;
        sw_code = 4'hF;
        pulse(8'hC3, MIN_W);
        rd(8'h0B, 1, 1, got); check("R2 old pair silent", got, 8'h00);
        rd(8'h1E, 1, 1, got); check("R2 top pair status", got, 8'hFE);
        rd(8'h1F, 1, 1, got); check("R2 top pair data", got, 8'hC3);
        check("R6 top pair release", {7'h0, irq_n}, 8'h01);
    endtask

    task automatic t_transparent;
        @(negedge clk);
        ext_data = 8'h11; stb_pin = 1'b1;
        repeat (MIN_W + 4) @(negedge clk);
        rd(8'h1F, 1, 1, got); check("R9 held strobe first", got, 8'h11);
        ext_data = 8'h22;
        repeat (2) @(negedge clk);
        rd(8'h1F, 1, 1, got); check("R9 held strobe follows", got, 8'h22);
        ext_data = 8'h7E;
        repeat (2) @(negedge clk);
        rd(8'h1F, 1, 1, got); check("R9 held strobe follows again", got, 8'h7E);
        stb_pin = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                #1;
                t_reset();
                t_capture();
                t_short();
                t_decode();
                t_top_pair();
                t_transparent();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule